// File: doc/BRIEF.md
# Dual-Mode Accumulator Feedback Divider

This block is the digital division path of a frequency synthesizer that can lock in two ways. A VCO-rate clock drives a dual-modulus prescaler that divides by N or by N+1. A modulo-M accumulator adds the channel index k once per prescaler period. When the addition wraps, the prescaler divides by N+1 for the following period. In fractional mode each prescaler period produces one feedback pulse, so the average feedback ratio is N + k/M. The reference strobe passes straight through to the phase-detector reference output.

In integer mode a divide-by-M stage is switched into both phase-detector paths. Over any M consecutive accumulator steps the accumulator wraps exactly k times. Each feedback pulse therefore spans exactly N·M + k VCO cycles, and the reference pulse rate falls by the same factor M. Both modes give the same set of output frequencies with the same channel spacing. There is no spur shaping. Everything runs in the VCO clock domain: the reference arrives as a one-cycle strobe, and both outputs are registered one-cycle pulses.

Top module: `hyb_fb_divider`

## Requirements
- R1: While `rst` is high at a rising edge, both `fb_pulse` and `ref_pulse` are low after that edge. The accumulator, the prescaler counter and both divide-by-M counters return to zero.
- R2: The prescaler emits one period-end every N or every N+1 VCO cycles, with `n_div` at least 2. A feedback pulse is never high on two consecutive cycles.
- R3: The accumulator holds a value below M and adds `k_chan` (which must be below M) once per prescaler period. A wrap selects N+1 for exactly the next prescaler period, and the modulus select changes only at a period end.
- R4: In fractional mode (`mode_int`=0), every interval between feedback pulses is N or N+1 VCO cycles, and any M consecutive intervals sum to exactly M·N + k.
- R5: In fractional mode with k=0, every feedback interval is exactly N cycles.
- R6: In fractional mode, `ref_pulse` equals `ref_tick` delayed by one cycle.
- R7: In integer mode (`mode_int`=1), every feedback interval is exactly M·N + k VCO cycles. For example, N=4, M=5, k=1 gives 21. With M=64, k=63 and N=4 it gives 319.
- R8: In integer mode, `ref_pulse` fires once per M reference strobes, so its interval is M times the strobe interval.
- R9: The divide-by-M counters are held at zero in fractional mode and in reset. Leaving reset in integer mode with N=4, M=5, k=1, the first feedback pulse is seen 20 cycles after reset release, because the first wrap falls on the fifth period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_int | input | 1 | 0 selects fractional mode, 1 selects integer mode |
| n_div | input | NW | Prescaler base modulus N (2 or more) |
| k_chan | input | $clog2(M) | Channel index k, below M |
| ref_tick | input | 1 | One-cycle reference strobe |
| fb_pulse | output | 1 | Registered feedback pulse to the phase detector |
| ref_pulse | output | 1 | Registered reference pulse to the phase detector |

## Verification
The bench measures every feedback interval. It would catch an accumulator that compares with the wrong modulus, or that holds the N+1 select for more than one period: either error breaks the M·N+k sum over M intervals. A divide-by-M counter that is not cleared while bypassed would move the first integer-mode pulse away from cycle 20 after reset. With k=0 the fractional path must never divide by N+1. A wide instance with M=64 and k=63 checks the wrap at the top of the accumulator range. That case gives 319 cycles in both modes. A register path missing the wrap would give 256.

// File: rtl/hyb_pkg.sv
package hyb_pkg;
  typedef enum logic {
    DIV_FRAC = 1'b0,
    DIV_INT  = 1'b1
  } div_mode_e;
  localparam int PATH_FB  = 0;
  localparam int PATH_REF = 1;
  localparam int NUM_PATH = 2;
endpackage

// File: rtl/hyb_prescaler.sv
module hyb_prescaler #(
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] n_div,
  input  logic          mod_hi,
  output logic          term
);
  logic [NW:0] cnt;
  logic [NW:0] div_len;

  assign div_len = {1'b0, n_div} + {{NW{1'b0}}, mod_hi};
  assign term    = (cnt >= div_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (term) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R2
  pres_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (term && n_div >= 2) |=> !term);
endmodule

// File: rtl/hyb_mod_accum.sv
module hyb_mod_accum #(
  parameter int M = 64,
  localparam int KW = (M > 1) ? $clog2(M) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [KW-1:0] k_chan,
  output logic          mod_hi
);
  localparam logic [KW:0] M_L = (KW+1)'(M);
  logic [KW-1:0] acc;
  logic [KW:0]   sum;
  logic          wrap;

  assign sum  = {1'b0, acc} + {1'b0, k_chan};
  assign wrap = (sum >= M_L);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      mod_hi <= 1'b0;
    end else if (step) begin
      acc    <= wrap ? KW'(sum - M_L) : KW'(sum);
      mod_hi <= wrap;
    end
  end

  // R3
  acc_range_chk: assert property (@(posedge clk) disable iff (rst)
    (k_chan < KW'(M - 1) + 1'b1) |-> ({1'b0, acc} < M_L));
  // R3
  mod_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(mod_hi));
endmodule

// File: rtl/hyb_div_by_m.sv
module hyb_div_by_m #(
  parameter int M = 64,
  localparam int CW = (M > 1) ? $clog2(M) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  output logic term
);
  logic [CW-1:0] cnt;

  assign term = en && tick && (cnt == CW'(M - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick)  cnt <= term ? '0 : cnt + 1'b1;
  end

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt} < (CW+1)'(M)));
endmodule

// File: rtl/hyb_fb_divider.sv
module hyb_fb_divider #(
  parameter int NW = 8,
  parameter int M  = 64,
  localparam int KW = (M > 1) ? $clog2(M) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_int,
  input  logic [NW-1:0] n_div,
  input  logic [KW-1:0] k_chan,
  input  logic          ref_tick,
  output logic          fb_pulse,
  output logic          ref_pulse
);
  import hyb_pkg::*;

  div_mode_e mode;
  logic      pre_term;
  logic      mod_hi;
  logic [NUM_PATH-1:0] path_in;
  logic [NUM_PATH-1:0] path_div;

  assign mode = div_mode_e'(mode_int);

  hyb_prescaler #(.NW(NW)) u_pres (
    .clk(clk), .rst(rst), .n_div(n_div), .mod_hi(mod_hi), .term(pre_term)
  );

  hyb_mod_accum #(.M(M)) u_acc (
    .clk(clk), .rst(rst), .step(pre_term), .k_chan(k_chan), .mod_hi(mod_hi)
  );

  assign path_in[PATH_FB]  = pre_term;
  assign path_in[PATH_REF] = ref_tick;

  for (genvar p = 0; p < NUM_PATH; p++) begin : g_path
    hyb_div_by_m #(.M(M)) u_divm (
      .clk(clk), .rst(rst), .en(mode == DIV_INT),
      .tick(path_in[p]), .term(path_div[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_pulse  <= 1'b0;
      ref_pulse <= 1'b0;
    end else begin
      fb_pulse  <= (mode == DIV_INT) ? path_div[PATH_FB]  : path_in[PATH_FB];
      ref_pulse <= (mode == DIV_INT) ? path_div[PATH_REF] : path_in[PATH_REF];
    end
  end

  // R2
  fb_single_chk: assert property (@(posedge clk) disable iff (rst)
    (fb_pulse && n_div >= 2) |=> !fb_pulse);
  // R6
  ref_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(mode_int) && !$past(rst)) |-> (ref_pulse == $past(ref_tick)));
endmodule

// File: tb/hyb_fb_divider_test.sv
`timescale 1ns/1ps
module hyb_fb_divider_test;
  localparam int NW = 8;
  localparam int MS = 5;
  localparam int MW = 64;
  localparam int NV = 4;
  localparam int RP = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_int = 1'b0;
  logic [NW-1:0] n_div = NW'(NV);
  logic [2:0] k_s = 3'd0;
  logic [5:0] k_w = 6'd0;
  logic ref_tick = 1'b0;
  logic fb_s, ref_s, fb_w, ref_w;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rcnt = 0;

  always #2 clk = ~clk;

  hyb_fb_divider #(.NW(NW), .M(MS)) uut (
    .clk(clk), .rst(rst), .mode_int(mode_int), .n_div(n_div), .k_chan(k_s),
    .ref_tick(ref_tick), .fb_pulse(fb_s), .ref_pulse(ref_s));

  hyb_fb_divider #(.NW(NW), .M(MW)) uut_wide (
    .clk(clk), .rst(rst), .mode_int(mode_int), .n_div(n_div), .k_chan(k_w),
    .ref_tick(ref_tick), .fb_pulse(fb_w), .ref_pulse(ref_w));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    rcnt <= (rcnt == RP - 1) ? 0 : rcnt + 1;
    ref_tick <= (rcnt == RP - 1);
  end

  function automatic logic sig(input int which);
    case (which)
      0: sig = fb_s;
      1: sig = ref_s;
      default: sig = fb_w;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(input int which, input int nint,
                         output int sum, output int mn, output int mx);
    int len;
    sum = 0; mn = 1 << 30; mx = 0;
    do @(negedge clk); while (!sig(which) && cyc < 150000);
    for (int i = 0; i < nint; i++) begin
      len = 0;
      do begin @(negedge clk); len++; end while (!sig(which) && cyc < 150000);
      sum += len;
      if (len < mn) mn = len;
      if (len > mx) mx = len;
    end
  endtask

  task automatic do_reset(input logic md);
    rst = 1'b1; mode_int = md;
    repeat (3) @(negedge clk);
    check("R1 fb low in reset", fb_s, 0);
    check("R1 ref low in reset", ref_s, 0);
    rst = 1'b0;
  endtask

  task automatic test_first_int;
    int n;
    k_s = 3'd1;
    do_reset(1'b1);
    n = 0;
    do begin @(negedge clk); n++; end while (!fb_s && n < 200);
    check("R9 first integer pulse", n, MS * NV);
  endtask

  task automatic test_frac(input int k);
    int s, mn, mx;
    k_s = 3'(k); mode_int = 1'b0;
    measure(0, 2, s, mn, mx);
    measure(0, MS, s, mn, mx);
    check("R4 fractional sum", s, MS * NV + k);
    check("R3 min interval >= N", int'(mn >= NV), 1);
    check("R3 max interval <= N+1", int'(mx <= NV + 1), 1);
    if (k == 0) check("R5 k=0 exact N", mx, NV);
  endtask

  task automatic test_int(input int k);
    int s, mn, mx;
    k_s = 3'(k); mode_int = 1'b1;
    measure(0, 2, s, mn, mx);
    measure(0, 4, s, mn, mx);
    check("R7 integer min", mn, MS * NV + k);
    check("R7 integer max", mx, MS * NV + k);
  endtask

  task automatic test_ref;
    int s, mn, mx;
    mode_int = 1'b0;
    measure(1, 2, s, mn, mx);
    measure(1, 4, s, mn, mx);
    check("R6 fractional ref min", mn, RP);
    check("R6 fractional ref max", mx, RP);
    mode_int = 1'b1;
    measure(1, 2, s, mn, mx);
    measure(1, 3, s, mn, mx);
    check("R8 integer ref min", mn, RP * MS);
    check("R8 integer ref max", mx, RP * MS);
  endtask

  task automatic test_wide;
    int s, mn, mx;
    k_w = 6'd63; mode_int = 1'b0;
    measure(2, 2, s, mn, mx);
    measure(2, MW, s, mn, mx);
    check("R4 wide fractional sum", s, MW * NV + 63);
    mode_int = 1'b1;
    measure(2, 2, s, mn, mx);
    measure(2, 2, s, mn, mx);
    check("R7 wide integer min", mn, MW * NV + 63);
    check("R7 wide integer max", mx, MW * NV + 63);
  endtask

  initial begin
    do_reset(1'b0);
    test_first_int();
    test_frac(1);
    test_frac(3);
    test_frac(0);
    test_int(1);
    test_int(4);
    test_int(0);
    test_ref();
    test_wide();
    if (cyc >= 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 160000);
    errors++;
    $display("FAIL watchdog hang: actual %0d expected below %0d", cyc, 160000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule